// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls one port of sixteen general-purpose pins. Software reaches it through a plain word-addressed register bus: an address, a write strobe, write data, and read data that follows the address combinationally. On the pad side, each pin has five signals. Four come out of the block: a driven value, a driver enable, a pull-up enable and a pull-down enable. One goes in: the level sampled from the pad.

Each pin has a 4-bit field in one of two configuration words. Pins 0 to 7 sit in the low word and pins 8 to 15 in the high word.

- The two low bits of a field are the direction code. Zero means input and any other value means output. The three non-zero codes behave the same here.
- The two high bits are the sub-mode.
  - For an input, the sub-mode picks floating or pulled. A pulled pin takes its pull direction from its own output-data bit.
  - For an output, the sub-mode picks push-pull or open-drain, and whether the value comes from the output data register or from a per-pin alternate-function signal.

Software changes output bits in one of three ways: a full write to the output data register, an atomic set/clear write, or a clear-only write. The pad levels pass through a two-stage synchronizer into the input data register. That register reflects the real pin level in every mode.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset both configuration words read 0x44444444 (every field floating input), the output data register reads 0, and all driver and pull enables are 0.
- R2: Pin n uses bits [4(n mod 8)+3 : 4(n mod 8)] of the low word (address 0) for n<8 and of the high word (address 1) for n>=8. Within that field, bits [1:0] are the direction code and bits [3:2] the sub-mode. Written configuration words read back unchanged.
- R3: A pin with direction code 00 never drives (enable 0, value 0). With sub-mode 00, 01 or 11 it also has both pulls off.
- R4: An input pin with sub-mode 10 enables only the pull-up when its output-data bit is 1, and only the pull-down when that bit is 0.
- R5: An output pin (direction code not 00) never enables a pull. With sub-mode 00 it drives its output-data bit with the driver enabled.
- R6: An open-drain output (sub-mode bit 2 set) always presents value 0. Its driver is enabled only when its source value is 0.
- R7: With sub-mode 10 or 11 on an output pin, the source value is that pin's alternate-function input instead of its output-data bit.
- R8: Address 2 reads the pad levels in bits 15:0, two clocks after they are applied, in any mode. Bits 31:16 read 0.
- R9: A write to address 4 sets output-data bits where bits 15:0 are 1 and clears them where bits 31:16 are 1. When both are 1 for the same bit, the set wins. A 0 leaves the bit unchanged. The address reads 0.
- R10: A write to address 5 clears output-data bits where bits 15:0 are 1. Bits 31:16 of that write have no effect.
- R11: A write to address 3 loads the output data register from bits 15:0. A read of address 3 returns it with bits 31:16 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Word address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| alt_out | input | 16 | Per-pin alternate-function output value |
| pad_in | input | 16 | Level sampled from each pad |
| pad_out | output | 16 | Value presented to each pad driver |
| pad_oe | output | 16 | Driver enable per pad |
| pad_pu | output | 16 | Pull-up enable per pad |
| pad_pd | output | 16 | Pull-down enable per pad |

## Verification
The pad controls decode combinationally from the stored configuration and output data. A corrupted field or output-data bit therefore shows on that pin's enables in the cycle after the write that caused it. The bench checks at exactly that point.

A fault in the set/clear precedence or in the clear-only masking surfaces as a wrong bit at the next read of address 3, and on pad_out of any push-pull pin. Synchronizer faults appear as a wrong input-register value exactly one or two clocks after a pad change.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W  = 3;
  localparam int FIELD_W = 4;

  localparam logic [ADDR_W-1:0] A_CFG_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_IN     = 3'd2;
  localparam logic [ADDR_W-1:0] A_OUT    = 3'd3;
  localparam logic [ADDR_W-1:0] A_SETCLR = 3'd4;
  localparam logic [ADDR_W-1:0] A_CLR    = 3'd5;

  localparam logic [1:0] DIR_INPUT   = 2'b00;
  localparam logic [1:0] SUB_PULL_IN = 2'b10;

  typedef struct packed {
    logic [1:0] sub;
    logic [1:0] dir;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{sub: 2'b01, dir: 2'b00};
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = raw_in;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DATA_W   = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [NUM_PINS*FIELD_W-1:0] cfg_flat,
  output logic [NUM_PINS-1:0]         odr
);
  localparam int CFG_BITS  = NUM_PINS * FIELD_W;
  localparam int CFG_WORDS = CFG_BITS / DATA_W;

  logic [CFG_BITS-1:0] cfg_q, cfg_d;
  logic [CFG_WORDS-1:0] cfg_we;
  logic                 cfg_en;
  logic [NUM_PINS-1:0]  odr_q, odr_d;
  logic                 odr_en;
  logic [NUM_PINS-1:0]  set_mask, clr_mask;

  assign set_mask = wr_data[NUM_PINS-1:0];
  assign clr_mask = wr_data[DATA_W-1 -: NUM_PINS];

  for (genvar k = 0; k < CFG_WORDS; k++) begin : g_cfg_word
    localparam logic [ADDR_W-1:0] WORD_ADDR = A_CFG_LO + ADDR_W'(k);
    assign cfg_we[k] = wr_en && (wr_addr == WORD_ADDR);
    always_comb begin
      cfg_d[k*DATA_W +: DATA_W] = cfg_we[k] ? wr_data : cfg_q[k*DATA_W +: DATA_W];
    end
  end

  assign cfg_en = |cfg_we;

  always_comb begin
    odr_d  = odr_q;
    odr_en = 1'b0;
    if (wr_en) begin
      case (wr_addr)
        A_OUT: begin
          odr_d  = set_mask;
          odr_en = 1'b1;
        end
        A_SETCLR: begin
          odr_d  = (odr_q & ~clr_mask) | set_mask;
          odr_en = 1'b1;
        end
        A_CLR: begin
          odr_d  = odr_q & ~set_mask;
          odr_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= {NUM_PINS{CFG_RESET}};
    else if (cfg_en) cfg_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      odr_q <= '0;
    else if (odr_en) odr_q <= odr_d;
  end

  assign cfg_flat = cfg_q;
  assign odr      = odr_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_SETCLR) |=> ((odr_q & $past(set_mask)) == $past(set_mask))); // R9
  AST_CLR_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_SETCLR) |=> ((odr_q & $past(clr_mask & ~set_mask)) == '0)); // R9
  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CLR) |=> ((odr_q & $past(set_mask)) == '0)); // R10
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q)); // R2
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_port_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [FIELD_W-1:0]    cfg,
  input  logic                  odr_bit,
  input  logic                  alt_bit,
  output logic                  drv_val,
  output logic                  drv_en,
  output logic                  pull_up,
  output logic                  pull_dn
);
  pin_cfg_t fld;
  logic     is_output;
  logic     open_drain;
  logic     src_val;

  assign fld        = pin_cfg_t'(cfg);
  assign is_output  = (fld.dir != DIR_INPUT);
  assign open_drain = fld.sub[0];
  assign src_val    = fld.sub[1] ? alt_bit : odr_bit;

  always_comb begin
    drv_val = 1'b0;
    drv_en  = 1'b0;
    pull_up = 1'b0;
    pull_dn = 1'b0;
    if (is_output) begin
      if (open_drain) begin
        drv_en = ~src_val;
      end else begin
        drv_en  = 1'b1;
        drv_val = src_val;
      end
    end else if (fld.sub == SUB_PULL_IN) begin
      pull_up = odr_bit;
      pull_dn = ~odr_bit;
    end
  end

  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pull_up && pull_dn)); // R4
  AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fld.dir == DIR_INPUT) |-> (!drv_en && !drv_val)); // R3
  AST_OUT_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    is_output |-> (!pull_up && !pull_dn)); // R5
  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (is_output && open_drain) |-> !drv_val); // R6
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] alt_out,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_pu,
  output logic [NUM_PINS-1:0] pad_pd
);
  localparam int CFG_BITS  = NUM_PINS * FIELD_W;
  localparam int CFG_WORDS = CFG_BITS / DATA_W;
  localparam int PAD_W     = DATA_W - NUM_PINS;

  logic                rst_int_n;
  logic [CFG_BITS-1:0] cfg_flat;
  logic [NUM_PINS-1:0] odr;
  logic [NUM_PINS-1:0] in_sync;

  gpio_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_int_n)
  );

  gpio_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) i_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (bus_we),
    .wr_addr  (bus_addr),
    .wr_data  (bus_wdata),
    .cfg_flat (cfg_flat),
    .odr      (odr)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_in_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .raw_in   (pad_in),
    .sync_out (in_sync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_ctrl i_pin (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .cfg     (cfg_flat[p*FIELD_W +: FIELD_W]),
      .odr_bit (odr[p]),
      .alt_bit (alt_out[p]),
      .drv_val (pad_out[p]),
      .drv_en  (pad_oe[p]),
      .pull_up (pad_pu[p]),
      .pull_dn (pad_pd[p])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < CFG_WORDS; k++) begin
      if (bus_addr == A_CFG_LO + ADDR_W'(k)) bus_rdata = cfg_flat[k*DATA_W +: DATA_W];
    end
    case (bus_addr)
      A_IN:    bus_rdata = {{PAD_W{1'b0}}, in_sync};
      A_OUT:   bus_rdata = {{PAD_W{1'b0}}, odr};
      default: ;
    endcase
  end

  AST_IN_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_addr == A_IN) |-> (bus_rdata[DATA_W-1:NUM_PINS] == '0)); // R8
  AST_STROBE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_addr == A_SETCLR || bus_addr == A_CLR) |-> (bus_rdata == '0)); // R9
endmodule

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] alt_out, pad_in;
  logic [15:0] pad_out, pad_oe, pad_pu, pad_pd;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  gpio_port_ctrl i_gpio_port_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_out(alt_out),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  // {cfg[3:0], odr, alt, exp oe, exp out, exp pu, exp pd}; cfg = {sub, dir}
  localparam logic [9:0] VEC [13] = '{
    10'b0100_1_0_0000, 10'b1000_1_0_0010, 10'b1000_0_0_0001,
    10'b0000_1_0_0000, 10'b1100_1_0_0000, 10'b0001_1_0_1100,
    10'b0010_0_1_1000, 10'b0111_0_0_1000, 10'b0101_1_0_0000,
    10'b1011_0_1_1100, 10'b1001_1_0_1000, 10'b1101_1_0_1000,
    10'b1110_0_1_0000
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic string vec_tag(input logic [3:0] c);
    if (c[1:0] == 2'b00) return (c[3:2] == 2'b10) ? "R4" : "R3";
    if (c[3])  return "R7";
    if (c[2])  return "R6";
    return "R5";
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    alt_out = '0; pad_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd0, r); check("R1 cfg low", r, 32'h4444_4444);
    rd(3'd1, r); check("R1 cfg high", r, 32'h4444_4444);
    rd(3'd3, r); check("R1 out data", r, 32'h0);
    check("R1 pads", {pad_oe, pad_pu}, 32'h0);
    check("R1 pull-down", {16'h0, pad_pd}, 32'h0);

    // vector table on pin 0
    foreach (VEC[i]) begin
      logic [9:0] v;
      v = VEC[i];
      alt_out = {15'h0, v[4]};
      wr(3'd3, {31'h0, v[5]});
      wr(3'd0, {28'h4444_444, v[9:6]});
      check(vec_tag(v[9:6]), {28'h0, pad_oe[0], pad_out[0], pad_pu[0], pad_pd[0]},
            {28'h0, v[3:0]});
      check("R3 other pins idle", {16'h0, pad_oe[15:1], 1'b0}, 32'h0);
    end

    // R2 field layout: pin 13 push-pull output, pin 3 pull input
    alt_out = '0;
    wr(3'd3, 32'h0000_2008);
    wr(3'd1, 32'h4414_4444);
    wr(3'd0, 32'h4444_8444);
    rd(3'd1, r); check("R2 cfg high readback", r, 32'h4414_4444);
    rd(3'd0, r); check("R2 cfg low readback", r, 32'h4444_8444);
    check("R2 pin13 drive", {pad_oe, pad_out}, {16'h2000, 16'h2000});
    check("R2 pin3 pull", {pad_pu, pad_pd}, {16'h0008, 16'h0000});

    // R11 output data write and readback
    wr(3'd3, 32'hABCD_1234);
    rd(3'd3, r); check("R11 out data", r, 32'h0000_1234);

    // R9 set/clear with set priority
    wr(3'd3, 32'h0000_00F0);
    wr(3'd4, 32'h0031_0101);
    rd(3'd3, r); check("R9 set/clear result", r, 32'h0000_01C1);
    rd(3'd4, r); check("R9 strobe reads zero", r, 32'h0);

    // R10 clear-only, upper half ignored
    wr(3'd5, 32'hFFFF_0041);
    rd(3'd3, r); check("R10 clear-only result", r, 32'h0000_0180);

    // R8 input register in output mode, two-clock latency
    wr(3'd0, 32'h1111_1111);
    wr(3'd1, 32'h1111_1111);
    wr(3'd3, 32'h0);
    check("R5 all push-pull low", {pad_oe, pad_out}, {16'hFFFF, 16'h0000});
    @(negedge clk);
    pad_in = 16'hA5C3;
    @(negedge clk);
    rd(3'd2, r); check("R8 one clock, not yet", r, 32'h0);
    @(negedge clk);
    rd(3'd2, r); check("R8 input readback", r, 32'h0000_A5C3);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule